// File: doc/BRIEF.md
# TLB Register Window Controller

This block sits beside a CPU's special-register file and gives software an indirect window onto a software-managed translation buffer. The CPU selects one of several register banks with a bank-select value and then reads or writes 32-bit special registers by index. Banks 1 and 2 are tied to two separate translation banks. In each of these banks, four registers have side effects: a high mirror, a low mirror, an entry selector and a fault-cause register. The other bank values behave as plain storage.

Software loads an entry in three steps. It points the selector at a set and slot. It writes the high mirror, and that value is copied into the cause register as well. It then writes the low mirror, which commits the whole entry: the low word is the written value and the high word is the cause register. On every commit, the block emits a one-cycle invalidate request for the page that the overwritten entry used to map, so that any downstream translation cache can drop it. A read in a translation bank first reloads both mirrors from the selected entry and then returns the data. A separate process-ID input raises a flush request whenever the low byte of the ID changes.

Top module: `tlbw_ctrl`

## Requirements
- R1: After reset, `rd_valid`, `inval_valid` and `pid_flush` are 0, and every special register reads back as 0.
- R2: With bank value 0 or 3, a write stores the data at the given index, and a later read of that bank and index returns it. Read data appears with `rd_valid` high on the clock edge after the read request.
- R3: With bank value 1 or 2, a write to index 3 (high mirror) also copies the data into index 6 (cause register) of the same bank.
- R4: With bank value 1 or 2, a write to index 5 (low mirror) commits an entry in that bank. The entry's low word is the data and its high word is the bank's cause register. The slot is taken from bits 3..0 of index 4 (selector) and the set from bits 5..4 of the same register.
- R5: One edge after each commit, `inval_valid` is high for exactly one cycle. At that point `inval_addr` holds bits 31..13 of the overwritten entry's high word, shifted left by 13. `inval_was_valid` holds bit 3 of the overwritten entry's low word.
- R6: In banks 1 and 2, a read of index 3 or 5 returns the selected entry's high or low word. This holds even if a plain write has since changed that mirror.
- R7: A read uses only bits 1..0 of the bank value, so bank value 5 reads bank 1 and bank value 4 reads bank 0.
- R8: A write whose bank value is 4 or more has no effect: no register changes, no entry commits, and no invalidate request is raised.
- R9: Bank values 1 and 2 address separate translation banks. A commit in one bank is not visible through the other.
- R10: A process-ID write raises `pid_flush` for one cycle only if its low 8 bits differ from those of the stored ID. `pid_flush_id` then carries the previous low byte. A write with an equal low byte raises no flush.
- R11: A read request in the same cycle as a write is ignored: `rd_valid` stays low. The write still takes effect.
- R12: A write to index 5 with bank value 0 or 3 stores plain data and raises no invalidate request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 8 | Current register-bank select value |
| wr_en | input | 1 | Special-register write strobe |
| wr_idx | input | 4 | Special-register write index |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Special-register read strobe |
| rd_idx | input | 4 | Special-register read index |
| rd_valid | output | 1 | Read data valid, one edge after the request |
| rd_data | output | 32 | Read data |
| pid_wr_en | input | 1 | Process-ID write strobe |
| pid_wr_data | input | 32 | New process ID |
| inval_valid | output | 1 | One-cycle page-invalidate request |
| inval_addr | output | 32 | Page address to invalidate |
| inval_was_valid | output | 1 | Valid bit of the overwritten entry |
| pid_flush | output | 1 | One-cycle flush-by-ID request |
| pid_flush_id | output | 8 | ID whose mappings are to be flushed |

## Verification
The hardest case to reach from the ports is a commit that overwrites a live entry, because the invalidate address must come from the old high word and not from the new one. The bench builds this up over several writes. It points the selector at set 2, slot 5, commits an entry with bit 3 of the low word set, and then loads a different high value and commits again at the same slot. That second commit must report the first entry's page and valid bit. The bench also overwrites a mirror with a plain write after a commit, to show that reads return the stored entry and not the stale mirror.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;

   // Classification of one special-register access in a cycle
   typedef enum logic [2:0] {
      ACC_NONE,
      ACC_PLAIN_WR,
      ACC_HI_WR,
      ACC_LO_WR,
      ACC_TLB_RD,
      ACC_PLAIN_RD
   } acc_kind_e;

   // Page base address of a high word: keep the bits above the page offset
   function automatic logic [31:0] page_base(input logic [31:0] hi_word,
                                             input int unsigned shift);
      logic [31:0] msk;
      msk = '1;
      msk = msk << shift;
      return hi_word & msk;
   endfunction

endpackage

// File: rtl/tlbw_sreg_file.sv
module tlbw_sreg_file #(
   parameter int DATA_W    = 32,
   parameter int RF_BANKS  = 4,
   parameter int NREGS     = 16,
   parameter int HI_IDX    = 3,
   parameter int LO_IDX    = 5,
   parameter int SEL_IDX   = 4,
   parameter int CAUSE_IDX = 6,
   localparam int BW       = $clog2(RF_BANKS),
   localparam int IW       = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BW-1:0]     wr_bank,
   input  logic [IW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cause_wr,
   input  logic              ld_en,
   input  logic [BW-1:0]     ld_bank,
   input  logic [DATA_W-1:0] ld_hi,
   input  logic [DATA_W-1:0] ld_lo,
   input  logic [BW-1:0]     rd_bank,
   input  logic [IW-1:0]     rd_idx,
   output logic [DATA_W-1:0] rd_word,
   input  logic [BW-1:0]     look_bank,
   output logic [DATA_W-1:0] sel_word,
   output logic [DATA_W-1:0] cause_word
);

   logic [DATA_W-1:0] rf [RF_BANKS][NREGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < RF_BANKS; b++) begin
            for (int r = 0; r < NREGS; r++) begin
               rf[b][r] <= '0;
            end
         end
      end else begin
         if (wr_en) begin
            rf[wr_bank][wr_idx] <= wr_data;
         end
         if (cause_wr) begin
            rf[wr_bank][CAUSE_IDX] <= wr_data;
         end
         if (ld_en) begin
            rf[ld_bank][HI_IDX] <= ld_hi;
            rf[ld_bank][LO_IDX] <= ld_lo;
         end
      end
   end

   assign rd_word    = rf[rd_bank][rd_idx];
   assign sel_word   = rf[look_bank][SEL_IDX];
   assign cause_word = rf[look_bank][CAUSE_IDX];

   // R3
   cause_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cause_wr |=> rf[$past(wr_bank)][CAUSE_IDX] == $past(wr_data))
      else $error("cause register did not take the high-mirror value");

endmodule

// File: rtl/tlbw_entry_store.sv
module tlbw_entry_store #(
   parameter int DATA_W     = 32,
   parameter int TLB_BANKS  = 2,
   parameter int SET_W      = 2,
   parameter int SLOT_W     = 4,
   parameter int PAGE_SHIFT = 13,
   parameter int VALID_BIT  = 3,
   parameter bit INVAL_ALL  = 1'b1,
   localparam int TB_W      = (TLB_BANKS > 1) ? $clog2(TLB_BANKS) : 1,
   localparam int ENTRIES   = TLB_BANKS * (1 << SET_W) * (1 << SLOT_W),
   localparam int AW        = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TB_W-1:0]   bank,
   input  logic [SET_W-1:0]  set,
   input  logic [SLOT_W-1:0] slot,
   input  logic              commit,
   input  logic [DATA_W-1:0] new_hi,
   input  logic [DATA_W-1:0] new_lo,
   output logic [DATA_W-1:0] cur_hi,
   output logic [DATA_W-1:0] cur_lo,
   output logic              inval_valid,
   output logic [DATA_W-1:0] inval_addr,
   output logic              inval_was_valid
);
   import tlbw_pkg::*;

   logic [DATA_W-1:0] hi_mem [ENTRIES];
   logic [DATA_W-1:0] lo_mem [ENTRIES];
   logic [AW-1:0]     addr;
   logic              fire;

   assign addr   = AW'({bank, set, slot});
   assign cur_hi = hi_mem[addr];
   assign cur_lo = lo_mem[addr];

   generate
      if (INVAL_ALL) begin : g_inval_every
         assign fire = commit;
      end else begin : g_inval_live
         assign fire = commit && cur_lo[VALID_BIT];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) begin
            hi_mem[e] <= '0;
            lo_mem[e] <= '0;
         end
         inval_valid     <= 1'b0;
         inval_addr      <= '0;
         inval_was_valid <= 1'b0;
      end else begin
         inval_valid <= fire;
         if (fire) begin
            inval_addr      <= DATA_W'(page_base(32'(cur_hi), PAGE_SHIFT));
            inval_was_valid <= cur_lo[VALID_BIT];
         end
         if (commit) begin
            hi_mem[addr] <= new_hi;
            lo_mem[addr] <= new_lo;
         end
      end
   end

   // R5
   inval_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inval_valid |-> $past(commit))
      else $error("invalidate request without a commit");

   // R5
   inval_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(inval_valid) |-> inval_addr[PAGE_SHIFT-1:0] == '0)
      else $error("invalidate address carries page-offset bits");

   generate
      if (INVAL_ALL) begin : g_follow_chk
         // R5
         commit_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
            commit |=> inval_valid)
            else $error("commit produced no invalidate request");
      end
   endgenerate

endmodule

// File: rtl/tlbw_pid_track.sv
module tlbw_pid_track #(
   parameter int DATA_W = 32,
   parameter int PID_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pid_wr_en,
   input  logic [DATA_W-1:0] pid_wr_data,
   output logic              pid_flush,
   output logic [PID_W-1:0]  pid_flush_id
);

   logic [DATA_W-1:0] pid_q;
   logic              changed;

   assign changed = pid_wr_en && (pid_wr_data[PID_W-1:0] != pid_q[PID_W-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pid_q        <= '0;
         pid_flush    <= 1'b0;
         pid_flush_id <= '0;
      end else begin
         pid_flush <= changed;
         if (changed) begin
            pid_flush_id <= pid_q[PID_W-1:0];
         end
         if (pid_wr_en) begin
            pid_q <= pid_wr_data;
         end
      end
   end

   // R10
   flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pid_flush |-> $past(pid_wr_en))
      else $error("flush request without an ID write");

   // R10
   same_pid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pid_wr_en && pid_wr_data[PID_W-1:0] == pid_q[PID_W-1:0]) |=> !pid_flush)
      else $error("flush raised for an unchanged ID");

endmodule

// File: rtl/tlbw_ctrl.sv
module tlbw_ctrl #(
   parameter int DATA_W     = 32,
   parameter int BANK_W     = 8,
   parameter int RF_BANKS   = 4,
   parameter int NREGS      = 16,
   parameter int HI_IDX     = 3,
   parameter int SEL_IDX    = 4,
   parameter int LO_IDX     = 5,
   parameter int CAUSE_IDX  = 6,
   parameter int SET_W      = 2,
   parameter int SLOT_W     = 4,
   parameter int PAGE_SHIFT = 13,
   parameter int VALID_BIT  = 3,
   parameter int PID_W      = 8,
   parameter bit INVAL_ALL  = 1'b1,
   localparam int BW        = $clog2(RF_BANKS),
   localparam int IW        = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] bank_sel,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [IW-1:0]     rd_idx,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   input  logic              pid_wr_en,
   input  logic [DATA_W-1:0] pid_wr_data,
   output logic              inval_valid,
   output logic [DATA_W-1:0] inval_addr,
   output logic              inval_was_valid,
   output logic              pid_flush,
   output logic [PID_W-1:0]  pid_flush_id
);
   import tlbw_pkg::*;

   generate
      if (PAGE_SHIFT < 1 || PAGE_SHIFT >= DATA_W) begin : g_bad_shift
         $error("PAGE_SHIFT must lie inside the data word");
      end
      if (HI_IDX == LO_IDX || HI_IDX == SEL_IDX || HI_IDX == CAUSE_IDX ||
          LO_IDX == SEL_IDX || LO_IDX == CAUSE_IDX || SEL_IDX == CAUSE_IDX) begin : g_bad_idx
         $error("window register indices must be distinct");
      end
      if (CAUSE_IDX >= NREGS || SEL_IDX >= NREGS || HI_IDX >= NREGS || LO_IDX >= NREGS) begin : g_bad_range
         $error("window register index outside the register bank");
      end
      if (SET_W + SLOT_W > DATA_W || VALID_BIT >= DATA_W) begin : g_bad_sel
         $error("selector or valid bit does not fit the data word");
      end
      if (RF_BANKS < 3 || (1 << BW) != RF_BANKS || BANK_W < BW) begin : g_bad_banks
         $error("RF_BANKS must be a power of two of at least 4");
      end
      if (PID_W > DATA_W) begin : g_bad_pid
         $error("PID_W exceeds the data word");
      end
   endgenerate

   // ---------------- access decode ----------------
   logic          wr_in_range;
   logic [BW-1:0] wr_bank;
   logic [BW-1:0] rd_bank;
   logic          wr_tlb, rd_tlb;
   logic          rd_go;
   acc_kind_e     kind;

   assign wr_in_range = (bank_sel < BANK_W'(RF_BANKS));
   assign wr_bank     = bank_sel[BW-1:0];
   assign rd_bank     = bank_sel[BW-1:0];
   assign wr_tlb      = (bank_sel == BANK_W'(1)) || (bank_sel == BANK_W'(2));
   assign rd_tlb      = (rd_bank == BW'(1)) || (rd_bank == BW'(2));
   assign rd_go       = rd_en && !wr_en;

   always_comb begin
      kind = ACC_NONE;
      if (wr_en) begin
         if (!wr_in_range)                                    kind = ACC_NONE;
         else if (wr_tlb && wr_idx == IW'(HI_IDX))           kind = ACC_HI_WR;
         else if (wr_tlb && wr_idx == IW'(LO_IDX))           kind = ACC_LO_WR;
         else                                                 kind = ACC_PLAIN_WR;
      end else if (rd_en) begin
         kind = rd_tlb ? ACC_TLB_RD : ACC_PLAIN_RD;
      end
   end

   // The active bank is the write bank for writes and the masked bank for reads
   logic [BW-1:0] act_bank;
   assign act_bank = wr_en ? wr_bank : rd_bank;

   // ---------------- register banks ----------------
   logic [DATA_W-1:0] rf_rd_word, sel_word, cause_word;
   logic [DATA_W-1:0] cur_hi, cur_lo;
   logic              rf_wr, cause_wr, mirror_ld;

   assign rf_wr     = (kind == ACC_PLAIN_WR) || (kind == ACC_HI_WR) || (kind == ACC_LO_WR);
   assign cause_wr  = (kind == ACC_HI_WR);
   assign mirror_ld = (kind == ACC_TLB_RD);

   tlbw_sreg_file #(
      .DATA_W   (DATA_W),
      .RF_BANKS (RF_BANKS),
      .NREGS    (NREGS),
      .HI_IDX   (HI_IDX),
      .LO_IDX   (LO_IDX),
      .SEL_IDX  (SEL_IDX),
      .CAUSE_IDX(CAUSE_IDX)
   ) u_sregs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (rf_wr),
      .wr_bank   (wr_bank),
      .wr_idx    (wr_idx),
      .wr_data   (wr_data),
      .cause_wr  (cause_wr),
      .ld_en     (mirror_ld),
      .ld_bank   (rd_bank),
      .ld_hi     (cur_hi),
      .ld_lo     (cur_lo),
      .rd_bank   (rd_bank),
      .rd_idx    (rd_idx),
      .rd_word   (rf_rd_word),
      .look_bank (act_bank),
      .sel_word  (sel_word),
      .cause_word(cause_word)
   );

   // ---------------- translation entries ----------------
   logic [SLOT_W-1:0] slot;
   logic [SET_W-1:0]  set;
   logic              tlb_bank;
   logic              commit;

   assign slot     = sel_word[SLOT_W-1:0];
   assign set      = sel_word[SLOT_W+SET_W-1:SLOT_W];
   assign tlb_bank = (act_bank == BW'(2));
   assign commit   = (kind == ACC_LO_WR);

   tlbw_entry_store #(
      .DATA_W    (DATA_W),
      .TLB_BANKS (2),
      .SET_W     (SET_W),
      .SLOT_W    (SLOT_W),
      .PAGE_SHIFT(PAGE_SHIFT),
      .VALID_BIT (VALID_BIT),
      .INVAL_ALL (INVAL_ALL)
   ) u_entries (
      .clk            (clk),
      .rst_n          (rst_n),
      .bank           (tlb_bank),
      .set            (set),
      .slot           (slot),
      .commit         (commit),
      .new_hi         (cause_word),
      .new_lo         (wr_data),
      .cur_hi         (cur_hi),
      .cur_lo         (cur_lo),
      .inval_valid    (inval_valid),
      .inval_addr     (inval_addr),
      .inval_was_valid(inval_was_valid)
   );

   // ---------------- read return ----------------
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = rf_rd_word;
      if (kind == ACC_TLB_RD) begin
         if (rd_idx == IW'(HI_IDX))      rd_next = cur_hi;
         else if (rd_idx == IW'(LO_IDX)) rd_next = cur_lo;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_go;
         if (rd_go) begin
            rd_data <= rd_next;
         end
      end
   end

   // ---------------- process ID ----------------
   tlbw_pid_track #(
      .DATA_W(DATA_W),
      .PID_W (PID_W)
   ) u_pid (
      .clk         (clk),
      .rst_n       (rst_n),
      .pid_wr_en   (pid_wr_en),
      .pid_wr_data (pid_wr_data),
      .pid_flush   (pid_flush),
      .pid_flush_id(pid_flush_id)
   );

   // R11
   rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(rd_en && !wr_en))
      else $error("read data valid without an accepted read");

   // R11
   wr_blocks_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !rd_valid)
      else $error("read accepted alongside a write");

   // R8
   oob_no_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_in_range) |=> !inval_valid)
      else $error("out-of-range bank write raised an invalidate");

endmodule

// File: tb/tlbw_ctrl_bench.sv
module tlbw_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bank_sel = '0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [3:0]  rd_idx = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        pid_wr_en = 1'b0;
   logic [31:0] pid_wr_data = '0;
   logic        inval_valid;
   logic [31:0] inval_addr;
   logic        inval_was_valid;
   logic        pid_flush;
   logic [7:0]  pid_flush_id;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tlbw_ctrl u_tlbw_ctrl (
      .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_data(rd_data),
      .pid_wr_en(pid_wr_en), .pid_wr_data(pid_wr_data),
      .inval_valid(inval_valid), .inval_addr(inval_addr),
      .inval_was_valid(inval_was_valid),
      .pid_flush(pid_flush), .pid_flush_id(pid_flush_id)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic do_wr(input logic [7:0] b, input logic [3:0] i, input logic [31:0] d);
      @(negedge clk);
      bank_sel = b; wr_en = 1'b1; wr_idx = i; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic do_rd(input logic [7:0] b, input logic [3:0] i,
                        output logic [31:0] d, output logic v);
      @(negedge clk);
      bank_sel = b; rd_en = 1'b1; rd_idx = i;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data; v = rd_valid;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] b, input logic [3:0] i,
                         input logic [31:0] exp);
      logic [31:0] d;
      logic v;
      do_rd(b, i, d, v);
      chk(req, {31'd0, v}, 32'd1);
      chk(req, d, exp);
   endtask

   task automatic t_reset;
      chk("R1", {31'd0, rd_valid}, 32'd0);
      chk("R1", {31'd0, inval_valid}, 32'd0);
      chk("R1", {31'd0, pid_flush}, 32'd0);
      rd_chk("R1", 8'd0, 4'd7, 32'd0);
      rd_chk("R1", 8'd1, 4'd6, 32'd0);
   endtask

   task automatic t_plain;
      do_wr(8'd0, 4'd7, 32'hA5A5_0001);
      rd_chk("R2", 8'd0, 4'd7, 32'hA5A5_0001);
      do_wr(8'd3, 4'd2, 32'h0B0B_0002);
      rd_chk("R2", 8'd3, 4'd2, 32'h0B0B_0002);
      rd_chk("R2", 8'd0, 4'd2, 32'd0);
   endtask

   task automatic t_cause_copy;
      do_wr(8'd1, 4'd3, 32'hC0DE_1111);
      rd_chk("R3", 8'd1, 4'd6, 32'hC0DE_1111);
   endtask

   task automatic t_commit;
      do_wr(8'd1, 4'd4, 32'h0000_0025);       // set 2, slot 5
      do_wr(8'd1, 4'd3, 32'h1234_7ABC);
      do_wr(8'd1, 4'd5, 32'h0000_0008);
      chk("R5", {31'd0, inval_valid}, 32'd1);
      chk("R5", inval_addr, 32'd0);
      chk("R5", {31'd0, inval_was_valid}, 32'd0);
      rd_chk("R4", 8'd1, 4'd3, 32'h1234_7ABC);
      rd_chk("R4", 8'd1, 4'd5, 32'h0000_0008);
      // overwrite the live entry
      do_wr(8'd1, 4'd3, 32'h0000_2000);
      do_wr(8'd1, 4'd5, 32'h0000_0000);
      chk("R5", {31'd0, inval_valid}, 32'd1);
      chk("R5", inval_addr, 32'h1234_6000);
      chk("R5", {31'd0, inval_was_valid}, 32'd1);
      @(negedge clk);
      chk("R5", {31'd0, inval_valid}, 32'd0);
      rd_chk("R4", 8'd1, 4'd3, 32'h0000_2000);
      rd_chk("R4", 8'd1, 4'd5, 32'h0000_0000);
      // a different slot stays empty
      do_wr(8'd1, 4'd4, 32'h0000_0024);
      rd_chk("R4", 8'd1, 4'd3, 32'd0);
      do_wr(8'd1, 4'd4, 32'h0000_0025);
   endtask

   task automatic t_mirror_reload;
      do_wr(8'd1, 4'd3, 32'hFFFF_0000);
      chk("R6", {31'd0, inval_valid}, 32'd0);
      rd_chk("R6", 8'd1, 4'd3, 32'h0000_2000);
      rd_chk("R6", 8'd1, 4'd6, 32'hFFFF_0000);
   endtask

   task automatic t_mask;
      rd_chk("R7", 8'd5, 4'd3, 32'h0000_2000);
      rd_chk("R7", 8'd4, 4'd7, 32'hA5A5_0001);
   endtask

   task automatic t_oob;
      do_wr(8'd9, 4'd5, 32'hDEAD_0000);
      chk("R8", {31'd0, inval_valid}, 32'd0);
      do_wr(8'd8, 4'd7, 32'hDEAD_0001);
      rd_chk("R8", 8'd1, 4'd5, 32'd0);
      rd_chk("R8", 8'd0, 4'd7, 32'hA5A5_0001);
   endtask

   task automatic t_bank_split;
      do_wr(8'd2, 4'd4, 32'h0000_0025);
      rd_chk("R9", 8'd2, 4'd3, 32'd0);
      rd_chk("R9", 8'd2, 4'd5, 32'd0);
      rd_chk("R9", 8'd1, 4'd3, 32'h0000_2000);
   endtask

   task automatic t_pid;
      @(negedge clk); pid_wr_en = 1'b1; pid_wr_data = 32'h0000_0005;
      @(negedge clk); pid_wr_en = 1'b0;
      chk("R10", {31'd0, pid_flush}, 32'd1);
      chk("R10", {24'd0, pid_flush_id}, 32'd0);
      @(negedge clk); pid_wr_en = 1'b1; pid_wr_data = 32'h0000_0105;
      @(negedge clk); pid_wr_en = 1'b0;
      chk("R10", {31'd0, pid_flush}, 32'd0);
      @(negedge clk); pid_wr_en = 1'b1; pid_wr_data = 32'h0000_0007;
      @(negedge clk); pid_wr_en = 1'b0;
      chk("R10", {31'd0, pid_flush}, 32'd1);
      chk("R10", {24'd0, pid_flush_id}, 32'h05);
      @(negedge clk);
      chk("R10", {31'd0, pid_flush}, 32'd0);
   endtask

   task automatic t_collide;
      @(negedge clk);
      bank_sel = 8'd0; wr_en = 1'b1; wr_idx = 4'd8; wr_data = 32'h0000_0055;
      rd_en = 1'b1; rd_idx = 4'd7;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
      chk("R11", {31'd0, rd_valid}, 32'd0);
      rd_chk("R11", 8'd0, 4'd8, 32'h0000_0055);
   endtask

   task automatic t_plain_lo;
      do_wr(8'd0, 4'd5, 32'h0000_0077);
      chk("R12", {31'd0, inval_valid}, 32'd0);
      rd_chk("R12", 8'd0, 4'd5, 32'h0000_0077);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_plain;
      t_cause_copy;
      t_commit;
      t_mirror_reload;
      t_mask;
      t_oob;
      t_bank_split;
      t_pid;
      t_collide;
      t_plain_lo;
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule